// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block keeps one 64-bit redirection entry per interrupt input and turns pending inputs into memory-write requests. Each entry programs the interrupt's vector, its destination ID, whether it is masked, and whether it is edge or level triggered. It also carries a status flag that shows a level interrupt is in service. When an unmasked input is pending, the block builds a 32-bit address from a fixed upper prefix and the entry's destination ID. The write data is the entry's vector. It presents the address and data on a valid/ready request port.

Broadcast end-of-interrupt messages arrive with a vector. That vector is compared in the same cycle against every entry, and each matching entry has its in-service flag cleared. The message is used only inside the block and goes nowhere else. Software programs entries through a simple indexed port that accesses either 32-bit half of an entry.

Top module: `irt_ctrl`

## Requirements
- R1: After reset every entry reads 0x0001_0000 in its low half and 0 in its high half, so every input is masked. No write request is pending.
- R2: A write with `reg_half`=0 updates entry bits 31:0, and a write with `reg_half`=1 updates bits 63:32. A read returns the stored half, but bit 14 (in-service flag) ignores software writes.
- R3: A request's address is 0xFEE in bits 31:20, the entry's bits 63:56 (destination ID) in bits 19:12, and zero in bits 11:0.
- R4: The write data is entry bits 7:0 (vector), zero-extended to 32 bits.
- R5: An edge entry (bit 15 = 0) produces exactly one write for each rising input edge. An input that stays high issues no second write, and a fresh rising edge issues another.
- R6: A masked entry (bit 16 = 1) issues no write. An edge seen while masked stays pending and is delivered once the mask is cleared.
- R7: For a level entry (bit 15 = 1), an accepted write sets bit 14. No further write is issued for that input while bit 14 stays set, even with the input held high.
- R8: An EOI clears bit 14 in every entry whose vector equals `eoi_vector` and leaves other entries unchanged. A level input still high then issues a new write.
- R9: When several inputs are eligible at once, the lowest index is served first, and only one request is outstanding at a time.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R11: Edge entries never set bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Entry index for read and write |
| reg_half | input | 1 | 0 selects bits 31:0, 1 selects bits 63:32 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected half of the indexed entry (combinational) |
| irq_in | input | NUM_IN | Interrupt input lines |
| wr_valid | output | 1 | Delivery write request valid |
| wr_ready | input | 1 | Downstream accepts the request |
| wr_addr | output | 32 | Delivery write address |
| wr_data | output | 32 | Delivery write data |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |

## Verification
The bench builds the block with NUM_IN = 4. This size lets it program every index and drive the lowest and highest priority inputs together. It can also place two level entries on one shared vector, so a single EOI must clear both. A fourth entry stays free to hold an edge pending behind its mask.

// File: rtl/irt_pkg.sv
package irt_pkg;
    localparam int VEC_LSB  = 0;
    localparam int VEC_W    = 8;
    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;
    localparam int DEST_LSB = 56;
    localparam int DEST_W   = 8;

    localparam logic [11:0] MSG_PREFIX = 12'hFEE;

    typedef logic [63:0] irt_entry_t;

    localparam irt_entry_t ENTRY_RST = 64'h0000_0000_0001_0000;

    function automatic logic [31:0] msg_addr(input irt_entry_t e);
        return {MSG_PREFIX, e[DEST_LSB +: DEST_W], 12'h000};
    endfunction

    function automatic logic [31:0] msg_data(input irt_entry_t e);
        return {24'h0, e[VEC_LSB +: VEC_W]};
    endfunction
endpackage

// File: rtl/irt_table.sv
module irt_table
    import irt_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [IDX_W-1:0]             reg_idx,
    input  logic                         reg_half,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         set_rirr,
    input  logic [IDX_W-1:0]             set_idx,
    input  logic                         eoi_valid,
    input  logic [7:0]                   eoi_vector,
    output irt_entry_t [NUM_IN-1:0]      entries_o
);
    typedef struct packed {
        irt_entry_t [NUM_IN-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        reg_rdata = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            // broadcast EOI: every matching entry clears in parallel
            if (eoi_valid && st_q.ent[i][VEC_LSB +: VEC_W] == eoi_vector)
                st_d.ent[i][RIRR_BIT] = 1'b0;
            // an accepted level delivery wins over a same-cycle EOI
            if (set_rirr && set_idx == IDX_W'(i))
                st_d.ent[i][RIRR_BIT] = 1'b1;
            if (reg_wr && reg_idx == IDX_W'(i)) begin
                if (reg_half)
                    st_d.ent[i][63:32] = reg_wdata;
                else
                    st_d.ent[i][31:0] = {reg_wdata[31:RIRR_BIT+1],
                                         st_d.ent[i][RIRR_BIT],
                                         reg_wdata[RIRR_BIT-1:0]};
            end
            if (reg_idx == IDX_W'(i))
                reg_rdata = reg_half ? st_q.ent[i][63:32] : st_q.ent[i][31:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IN; i++) st_q.ent[i] <= ENTRY_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign entries_o = st_q.ent;
endmodule

// File: rtl/irt_pending.sv
module irt_pending
    import irt_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       irq_in,
    input  irt_entry_t [NUM_IN-1:0] entries,
    input  logic                    clr_valid,
    input  logic [IDX_W-1:0]        clr_idx,
    output logic [NUM_IN-1:0]       eligible
);
    typedef struct packed {
        logic [NUM_IN-1:0] irr;
        logic [NUM_IN-1:0] prev;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        eligible  = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (entries[i][TRIG_BIT]) begin
                st_d.irr[i] = 1'b0;
                eligible[i] = ~entries[i][MASK_BIT] & irq_in[i] & ~entries[i][RIRR_BIT];
            end else begin
                if (clr_valid && clr_idx == IDX_W'(i))
                    st_d.irr[i] = 1'b0;
                if (irq_in[i] && !st_q.prev[i])
                    st_d.irr[i] = 1'b1;
                eligible[i] = ~entries[i][MASK_BIT] & st_q.irr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irt_arbiter.sv
module irt_arbiter
    import irt_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       eligible,
    input  irt_entry_t [NUM_IN-1:0] entries,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [31:0]             wr_addr,
    output logic [31:0]             wr_data,
    output logic                    fire,
    output logic [IDX_W-1:0]        fire_idx
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [31:0]      addr;
        logic [31:0]      data;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic [IDX_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NUM_IN - 1; i >= 0; i--)
            if (eligible[i]) pick = IDX_W'(i);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.valid) begin
            if (wr_ready) st_d.valid = 1'b0;
        end else if (|eligible) begin
            st_d.valid = 1'b1;
            st_d.idx   = pick;
            st_d.addr  = msg_addr(entries[pick]);
            st_d.data  = msg_data(entries[pick]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid = st_q.valid;
    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.data;
    assign fire     = st_q.valid & wr_ready;
    assign fire_idx = st_q.idx;
endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
    import irt_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_half,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [31:0]       wr_addr,
    output logic [31:0]       wr_data,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector
);
    irt_entry_t [NUM_IN-1:0] tbl_entries;
    logic [NUM_IN-1:0]       eligible;
    logic                    acc_fire;
    logic [IDX_W-1:0]        acc_idx;
    logic                    acc_level;

    assign acc_level = acc_fire & tbl_entries[acc_idx][TRIG_BIT];

    irt_table #(.NUM_IN(NUM_IN)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_idx    (reg_idx),
        .reg_half   (reg_half),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .set_rirr   (acc_level),
        .set_idx    (acc_idx),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .entries_o  (tbl_entries)
    );

    irt_pending #(.NUM_IN(NUM_IN)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .entries   (tbl_entries),
        .clr_valid (acc_fire),
        .clr_idx   (acc_idx),
        .eligible  (eligible)
    );

    irt_arbiter #(.NUM_IN(NUM_IN)) u_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .eligible (eligible),
        .entries  (tbl_entries),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fire     (acc_fire),
        .fire_idx (acc_idx)
    );
endmodule

// File: rtl/irt_ctrl_chk.sv
module irt_ctrl_chk
    import irt_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_valid,
    input logic                    wr_ready,
    input logic [31:0]             wr_addr,
    input logic [31:0]             wr_data,
    input logic                    eoi_valid,
    input logic [7:0]              eoi_vector,
    input irt_entry_t [NUM_IN-1:0] entries,
    input logic                    fire,
    input logic [IDX_W-1:0]        fire_idx
);
    AST_ADDR_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[31:20] == 12'hFEE);                               // R3
    AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[11:0] == 12'h000);                                // R3
    AST_DATA_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[31:8] == 24'h0);                                  // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R10

    for (genvar i = 0; i < NUM_IN; i++) begin : g_ent
        AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
            fire && fire_idx == IDX_W'(i) && entries[i][TRIG_BIT]
            |=> entries[i][RIRR_BIT]);                                         // R7
        AST_RIRR_ONLY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(entries[i][RIRR_BIT])
            |-> $past(fire && fire_idx == IDX_W'(i) && entries[i][TRIG_BIT])); // R11
        AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_valid && entries[i][VEC_LSB +: VEC_W] == eoi_vector
            && !(fire && fire_idx == IDX_W'(i) && entries[i][TRIG_BIT])
            |=> !entries[i][RIRR_BIT]);                                        // R8
    end
endmodule

bind irt_ctrl irt_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .entries    (tbl_entries),
    .fire       (acc_fire),
    .fire_idx   (acc_idx)
);

// File: tb/tb_irt_ctrl.sv
`timescale 1ns/1ps
module tb_irt_ctrl;
    localparam int NUM_IN = 4;
    localparam int IDX_W  = 2;
    localparam int NVEC   = 5;

    // {idx[66:65], half[64], wdata[63:32], expected readback[31:0]}
    localparam logic [66:0] VECS [0:NVEC-1] = '{
        {2'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_BFFF},
        {2'd1, 1'b1, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
        {2'd2, 1'b0, 32'h0000_4000, 32'h0000_0000},
        {2'd3, 1'b1, 32'h1234_5678, 32'h1234_5678},
        {2'd3, 1'b0, 32'h0001_40FF, 32'h0001_00FF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [IDX_W-1:0]  reg_idx = '0;
    logic              reg_half = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NUM_IN-1:0] irq_in = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [31:0]       wr_addr;
    logic [31:0]       wr_data;
    logic              eoi_valid = 1'b0;
    logic [7:0]        eoi_vector = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irt_ctrl #(.NUM_IN(NUM_IN)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [IDX_W-1:0] idx, input logic half, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_half = half; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [IDX_W-1:0] idx, input logic half, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx; reg_half = half;
        #1 d = reg_rdata;
    endtask

    task automatic wait_req(input string req);
        logic ok = 1'b0;
        for (int k = 0; k < 30 && !ok; k++) begin
            @(negedge clk);
            ok = wr_valid;
        end
        chk(req, {31'b0, ok}, 32'd1);
    endtask

    task automatic take();
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
    endtask

    task automatic idle_check(input string req, input int n);
        logic seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            seen = seen | wr_valid;
        end
        chk(req, {31'b0, seen}, 32'd0);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        #500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset contents and idle request port
        for (int i = 0; i < NUM_IN; i++) begin
            reg_read(IDX_W'(i), 1'b0, rd); chk("R1 low", rd, 32'h0001_0000);
            reg_read(IDX_W'(i), 1'b1, rd); chk("R1 high", rd, 32'h0);
        end
        chk("R1 valid", {31'b0, wr_valid}, 32'd0);

        // R2: register write/read vectors, bit 14 read-only
        for (int v = 0; v < NVEC; v++) begin
            reg_write(VECS[v][66:65], VECS[v][64], VECS[v][63:32]);
            reg_read(VECS[v][66:65], VECS[v][64], rd);
            chk("R2", rd, VECS[v][31:0]);
        end

        // configure: 0 edge vec30 dst11; 1,2 level vec41 dst22/44; 3 edge masked vec52 dst55
        reg_write(2'd0, 1'b1, 32'h1100_0000); reg_write(2'd0, 1'b0, 32'h0000_0030);
        reg_write(2'd1, 1'b1, 32'h2200_0000); reg_write(2'd1, 1'b0, 32'h0000_8041);
        reg_write(2'd2, 1'b1, 32'h4400_0000); reg_write(2'd2, 1'b0, 32'h0000_8041);
        reg_write(2'd3, 1'b1, 32'h5500_0000); reg_write(2'd3, 1'b0, 32'h0001_0052);

        // R3 R4 R5 R10: edge delivery
        @(negedge clk) irq_in[0] = 1'b1;
        wait_req("R5 edge request");
        chk("R3 addr", wr_addr, 32'hFEE1_1000);
        chk("R4 data", wr_data, 32'h0000_0030);
        repeat (3) @(negedge clk);
        chk("R10 valid held", {31'b0, wr_valid}, 32'd1);
        chk("R10 addr held", wr_addr, 32'hFEE1_1000);
        chk("R10 data held", wr_data, 32'h0000_0030);
        take();
        idle_check("R5 held input", 10);
        reg_read(2'd0, 1'b0, rd); chk("R11 edge no rirr", rd, 32'h0000_0030);
        @(negedge clk) irq_in[0] = 1'b0;
        @(negedge clk) irq_in[0] = 1'b1;
        wait_req("R5 second edge");
        chk("R5 addr", wr_addr, 32'hFEE1_1000);
        take();
        @(negedge clk) irq_in[0] = 1'b0;

        // R9 R7: two level inputs together
        @(negedge clk) irq_in[2:1] = 2'b11;
        wait_req("R9 first");
        chk("R9 lowest first", wr_addr, 32'hFEE2_2000);
        chk("R4 level data", wr_data, 32'h0000_0041);
        take();
        wait_req("R9 second");
        chk("R9 next", wr_addr, 32'hFEE4_4000);
        take();
        reg_read(2'd1, 1'b0, rd); chk("R7 rirr set 1", rd, 32'h0000_C041);
        reg_read(2'd2, 1'b0, rd); chk("R7 rirr set 2", rd, 32'h0000_C041);
        idle_check("R7 no redelivery", 10);

        // R8: non-matching then matching EOI
        send_eoi(8'h30);
        reg_read(2'd1, 1'b0, rd); chk("R8 nonmatch kept", rd, 32'h0000_C041);
        chk("R8 nonmatch idle", {31'b0, wr_valid}, 32'd0);
        send_eoi(8'h41);
        reg_read(2'd1, 1'b0, rd); chk("R8 clear 1", rd, 32'h0000_8041);
        reg_read(2'd2, 1'b0, rd); chk("R8 clear 2", rd, 32'h0000_8041);
        reg_read(2'd3, 1'b0, rd); chk("R8 other kept", rd, 32'h0001_0052);
        wait_req("R8 redelivery");
        chk("R8 addr 1", wr_addr, 32'hFEE2_2000);
        take();
        wait_req("R8 redelivery 2");
        chk("R8 addr 2", wr_addr, 32'hFEE4_4000);
        take();
        @(negedge clk) irq_in[2:1] = 2'b00;

        // R6: masked edge held pending until unmask
        @(negedge clk) irq_in[3] = 1'b1;
        idle_check("R6 masked", 10);
        @(negedge clk) irq_in[3] = 1'b0;
        reg_write(2'd3, 1'b0, 32'h0000_0052);
        wait_req("R6 after unmask");
        chk("R6 addr", wr_addr, 32'hFEE5_5000);
        chk("R6 data", wr_data, 32'h0000_0052);
        take();
        idle_check("R6 single", 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule